// File: doc/BRIEF.md
# Packed Vector Register Allocation Decoder

This block turns one packed configuration value into the per-register element width and element type codes of a 32-entry vector register file. The value has one 5-bit field for each datatype. A nonzero field names the highest register that belongs to that datatype. Reading upward from v0, each datatype takes the registers up to and including its named register. A zero field gives its datatype no registers at all. The decoder checks the value before it applies it. It then writes every width and type field into the configuration bank in a single cycle, and clears the predicate-register count at the same time. One cycle later it pulses the data-register clear and the vector-length reload. With that pulse it returns the maximum vector length, which an external table produces from the newly written widths.

There are two request forms. The full form carries the whole packed value. The short form carries only a 5-bit immediate. An all-zero value leaves the unit unconfigured. In that state the decoder returns a maximum vector length of zero, and any non-configuration vector operation that is reported to it raises a trap.

Top module: `vcfg_decode`

## Requirements
- R1: Field k of the value occupies bits 5k+4..5k. In order k = 0..8, the fields belong to X8, X16, F16, X32, F32, X64, F64, X128 and F128. Every register owned by a datatype gets its width code and its type code. Width codes are 8-bit=1000, 16-bit=1001, 32-bit=1010, 64-bit=1011, 128-bit=1100. Type codes are X8=1000, X16=1001, X32=1010, X64=1011, X128=1100, F16=0001, F32=0010, F64=0011, F128=0100. Register n occupies bits 4n+3..4n of bank_width and of bank_type.
- R2: Register n belongs to the lowest-numbered nonzero field whose value is at least n. The lowest nonzero field therefore starts at v0, and a field of value 1 yields exactly v0 and v1.
- R3: Every register above the largest nonzero field has width code 0000 and type code 0000.
- R4: A value whose nonzero fields are not strictly increasing with field index is rejected. A rejected value gives a one-cycle illegal pulse, no bank write and no pulses, and leaves the bank fields and the configured flag unchanged.
- R5: A nonzero field for a datatype that the SUPPORT parameter excludes is rejected in the same way. By default F128 is excluded.
- R6: An all-zero value is accepted. It writes every register as disabled, drops the configured flag and returns 0 as the maximum vector length.
- R7: Each accepted request asserts npred_we together with bank_we, with npred_val equal to 0.
- R8: When req_imm is 1, req_imm_val is used as the X8 field and all other fields are zero.
- R9: A request sampled on a clock edge shows bank_we (or illegal) after that edge. After the next edge, clr_pulse and vl_load are high for one cycle. At that point vl_val holds mvl_in as sampled during the bank_we cycle, or 0 when the result is unconfigured.
- R10: A vop_valid sampled while the unit is unconfigured gives a one-cycle vop_trap after that edge. The check uses the configured state in force before any request in the same cycle.
- R11: After reset, configured is 0, all bank fields are 0, vl_val is 0 and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Configuration request strobe |
| req_imm | input | 1 | Selects the 5-bit immediate form |
| req_word | input | 45 | Full packed allocation value |
| req_imm_val | input | 5 | Immediate allocation value |
| vop_valid | input | 1 | A non-configuration vector operation is issuing |
| mvl_in | input | 16 | Maximum vector length from the external table |
| bank_we | output | 1 | Write strobe for all width and type fields |
| bank_width | output | 128 | Width codes, 4 bits per register |
| bank_type | output | 128 | Type codes, 4 bits per register |
| npred_we | output | 1 | Write strobe for the predicate count |
| npred_val | output | 4 | Predicate count value (always 0) |
| clr_pulse | output | 1 | Zero the data registers and set the predicates |
| vl_load | output | 1 | Reload the vector length |
| vl_val | output | 16 | Returned maximum vector length |
| configured | output | 1 | Unit holds a nonzero allocation |
| illegal | output | 1 | Request rejected |
| vop_trap | output | 1 | Vector operation issued while unconfigured |

## Verification
A configuration request and a vector operation can arrive in the same cycle. In that case the trap decision and the configured-state update happen on the same edge. The bench issues a configuring request together with vop_valid while the unit is unconfigured, and expects the trap to appear alongside bank_we. It then issues an unconfiguring request together with vop_valid while the unit is configured, and expects no trap. The scoreboard orders the expected trap ahead of the write, so a trap that is missing or extra shows up as a mismatch.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  localparam int NTYPE = 9;
  localparam int CW    = 4;

  // datatype index order: X8 X16 F16 X32 F32 X64 F64 X128 F128
  function automatic logic [CW-1:0] type_code(input int idx);
    logic [CW-1:0] c;
    case (idx)
      0:       c = 4'b1000;
      1:       c = 4'b1001;
      2:       c = 4'b0001;
      3:       c = 4'b1010;
      4:       c = 4'b0010;
      5:       c = 4'b1011;
      6:       c = 4'b0011;
      7:       c = 4'b1100;
      8:       c = 4'b0100;
      default: c = 4'b0000;
    endcase
    return c;
  endfunction

  function automatic logic [CW-1:0] width_code(input int idx);
    logic [CW-1:0] c;
    case (idx)
      0:       c = 4'b1000;
      1, 2:    c = 4'b1001;
      3, 4:    c = 4'b1010;
      5, 6:    c = 4'b1011;
      7, 8:    c = 4'b1100;
      default: c = 4'b0000;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/vcfg_check.sv
module vcfg_check
  import vcfg_pkg::*;
#(
  parameter int             FW      = 5,
  parameter logic [NTYPE-1:0] SUPPORT = 9'h0FF
) (
  input  logic [NTYPE*FW-1:0] word,
  output logic                legal,
  output logic                any_set
);

  always_comb begin
    logic [FW-1:0] hi;
    logic [FW-1:0] f;
    logic          seen;
    legal = 1'b1;
    seen  = 1'b0;
    hi    = '0;
    for (int i = 0; i < NTYPE; i++) begin
      f = word[i*FW +: FW];
      if (f != '0) begin
        if (!SUPPORT[i]) legal = 1'b0;
        if (seen && (f <= hi)) legal = 1'b0;
        seen = 1'b1;
        hi   = f;
      end
    end
    any_set = seen;
  end

endmodule

// File: rtl/vcfg_map.sv
module vcfg_map
  import vcfg_pkg::*;
#(
  parameter int REGS = 32,
  parameter int FW   = 5
) (
  input  logic [NTYPE*FW-1:0] word,
  output logic [REGS*CW-1:0]  map_width,
  output logic [REGS*CW-1:0]  map_type
);

  for (genvar r = 0; r < REGS; r++) begin : g_reg
    always_comb begin
      logic [FW-1:0] f;
      logic          found;
      found = 1'b0;
      map_width[r*CW +: CW] = '0;
      map_type[r*CW +: CW]  = '0;
      for (int i = 0; i < NTYPE; i++) begin
        f = word[i*FW +: FW];
        if (!found && (f != '0) && (int'(f) >= r)) begin
          map_width[r*CW +: CW] = width_code(i);
          map_type[r*CW +: CW]  = type_code(i);
          found = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vcfg_seq.sv
module vcfg_seq
  import vcfg_pkg::*;
#(
  parameter int REGS = 32,
  parameter int MVLW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               legal,
  input  logic               any_set,
  input  logic [REGS*CW-1:0] map_width,
  input  logic [REGS*CW-1:0] map_type,
  input  logic               vop_valid,
  input  logic [MVLW-1:0]    mvl_in,
  output logic [REGS*CW-1:0] width_q,
  output logic [REGS*CW-1:0] type_q,
  output logic               we_q,
  output logic               apply_q,
  output logic               ill_q,
  output logic               cfg_q,
  output logic               trap_q,
  output logic [MVLW-1:0]    mvl_q
);

  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic               commit, reject;
  logic               cfg_d, we_d, apply_d, ill_d, trap_d;
  logic               mvl_en;
  logic [MVLW-1:0]    mvl_d;

  always_comb begin
    commit  = req_valid & legal;
    reject  = req_valid & ~legal;
    cfg_d   = any_set;
    we_d    = commit;
    ill_d   = reject;
    apply_d = we_q;
    trap_d  = vop_valid & ~cfg_q;
    mvl_en  = we_q;
    mvl_d   = cfg_q ? mvl_in : '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      width_q <= '0;
      type_q  <= '0;
      cfg_q   <= 1'b0;
    end else if (commit) begin
      width_q <= map_width;
      type_q  <= map_type;
      cfg_q   <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mvl_q <= '0;
    end else if (mvl_en) begin
      mvl_q <= mvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      we_q    <= 1'b0;
      apply_q <= 1'b0;
      ill_q   <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      we_q    <= we_d;
      apply_q <= apply_d;
      ill_q   <= ill_d;
      trap_q  <= trap_d;
    end
  end

  // R4
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ill_q |-> ($stable(width_q) && $stable(type_q) && $stable(cfg_q)));

  // R4
  write_or_reject_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({we_q, ill_q}));

  // R9
  apply_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    we_q |=> apply_q);

  // R6
  unconf_mvl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (apply_q && !cfg_q) |-> (mvl_q == '0));

  // R3
  disabled_pair_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !cfg_q |-> ((width_q == '0) && (type_q == '0)));

endmodule

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int               REGS    = 32,
  parameter int               MVLW    = 16,
  parameter logic [NTYPE-1:0] SUPPORT = 9'h0FF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_imm,
  input  logic [NTYPE*$clog2(REGS)-1:0]   req_word,
  input  logic [$clog2(REGS)-1:0]         req_imm_val,
  input  logic                            vop_valid,
  input  logic [MVLW-1:0]                 mvl_in,
  output logic                            bank_we,
  output logic [REGS*CW-1:0]              bank_width,
  output logic [REGS*CW-1:0]              bank_type,
  output logic                            npred_we,
  output logic [3:0]                      npred_val,
  output logic                            clr_pulse,
  output logic                            vl_load,
  output logic [MVLW-1:0]                 vl_val,
  output logic                            configured,
  output logic                            illegal,
  output logic                            vop_trap
);

  localparam int FW = $clog2(REGS);
  localparam int WW = NTYPE * FW;

  logic [WW-1:0]      word;
  logic               legal, any_set;
  logic [REGS*CW-1:0] map_width, map_type;

  always_comb begin
    word = req_imm ? {{(WW-FW){1'b0}}, req_imm_val} : req_word;
  end

  vcfg_check #(.FW(FW), .SUPPORT(SUPPORT)) u_check (
    .word    (word),
    .legal   (legal),
    .any_set (any_set)
  );

  vcfg_map #(.REGS(REGS), .FW(FW)) u_map (
    .word      (word),
    .map_width (map_width),
    .map_type  (map_type)
  );

  logic we_q, apply_q;

  vcfg_seq #(.REGS(REGS), .MVLW(MVLW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .legal     (legal),
    .any_set   (any_set),
    .map_width (map_width),
    .map_type  (map_type),
    .vop_valid (vop_valid),
    .mvl_in    (mvl_in),
    .width_q   (bank_width),
    .type_q    (bank_type),
    .we_q      (we_q),
    .apply_q   (apply_q),
    .ill_q     (illegal),
    .cfg_q     (configured),
    .trap_q    (vop_trap),
    .mvl_q     (vl_val)
  );

  always_comb begin
    bank_we   = we_q;
    npred_we  = we_q;
    npred_val = 4'd0;
    clr_pulse = apply_q;
    vl_load   = apply_q;
  end

endmodule

// File: tb/vcfg_decode_test.sv
module vcfg_decode_test;

  localparam int CLK_PERIOD = 10;
  localparam int REGS = 32;
  localparam int FW = 5;
  localparam int NT = 9;

  localparam logic [3:0] TY [NT] = '{4'b1000, 4'b1001, 4'b0001, 4'b1010, 4'b0010,
                                      4'b1011, 4'b0011, 4'b1100, 4'b0100};
  localparam logic [3:0] WD [NT] = '{4'b1000, 4'b1001, 4'b1001, 4'b1010, 4'b1010,
                                      4'b1011, 4'b1011, 4'b1100, 4'b1100};
  localparam logic [NT-1:0] SUP = 9'h0FF;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_imm = 0, vop_valid = 0;
  logic [NT*FW-1:0] req_word = '0;
  logic [FW-1:0] req_imm_val = '0;
  logic [15:0] mvl_in;
  logic bank_we, npred_we, clr_pulse, vl_load, configured, illegal, vop_trap;
  logic [127:0] bank_width, bank_type;
  logic [3:0] npred_val;
  logic [15:0] vl_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcfg_decode uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_imm(req_imm),
    .req_word(req_word), .req_imm_val(req_imm_val), .vop_valid(vop_valid),
    .mvl_in(mvl_in), .bank_we(bank_we), .bank_width(bank_width),
    .bank_type(bank_type), .npred_we(npred_we), .npred_val(npred_val),
    .clr_pulse(clr_pulse), .vl_load(vl_load), .vl_val(vl_val),
    .configured(configured), .illegal(illegal), .vop_trap(vop_trap)
  );

  // external table: 200 plus number of enabled registers
  always_comb begin
    int n;
    n = 0;
    for (int r = 0; r < REGS; r++) if (bank_width[r*4 +: 4] != 0) n++;
    mvl_in = 16'(200 + n);
  end

  typedef struct {
    int           kind;   // 0 trap, 1 illegal, 2 write, 3 response
    logic [127:0] w;
    logic [127:0] t;
    logic         cfg;
    logic [15:0]  mvl;
    string        req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  logic monitor_on = 0;
  logic [127:0] m_w = '0, m_t = '0;
  logic m_cfg = 0;

  function automatic logic [NT*FW-1:0] pack(input int a0, a1, a2, a3, a4, a5, a6, a7, a8);
    return {5'(a8), 5'(a7), 5'(a6), 5'(a5), 5'(a4), 5'(a3), 5'(a2), 5'(a1), 5'(a0)};
  endfunction

  task automatic model(input logic [NT*FW-1:0] v, output logic ok, output logic anyv,
                       output logic [127:0] w, output logic [127:0] t, output int top);
    int prev;
    ok = 1; anyv = 0; w = '0; t = '0; top = 0; prev = 0;
    for (int i = 0; i < NT; i++) begin
      int f;
      f = int'(v[i*FW +: FW]);
      if (f != 0) begin
        if (f <= prev || !SUP[i]) ok = 0;
        prev = f; anyv = 1;
        if (f > top) top = f;
      end
    end
    for (int i = NT-1; i >= 0; i--) begin
      int f;
      f = int'(v[i*FW +: FW]);
      if (f != 0)
        for (int r = 0; r <= f; r++) begin
          w[r*4 +: 4] = WD[i];
          t[r*4 +: 4] = TY[i];
        end
    end
  endtask

  task automatic fail(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic drive(input logic req, input logic imm, input logic [NT*FW-1:0] word,
                       input logic [FW-1:0] iv, input logic vop, input string tag);
    logic [NT*FW-1:0] v;
    logic ok, anyv;
    logic [127:0] w, t;
    int top;
    item_t it;
    v = imm ? {40'b0, iv} : word;
    model(v, ok, anyv, w, t, top);
    @(negedge clk);
    req_valid = req; req_imm = imm; req_word = word; req_imm_val = iv; vop_valid = vop;
    if (vop && !m_cfg) begin
      it = '{0, m_w, m_t, m_cfg, 16'd0, {"R10 ", tag}};
      q.push_back(it);
    end
    if (req) begin
      if (ok) begin
        m_w = w; m_t = t; m_cfg = anyv;
        it = '{2, w, t, anyv, 16'd0, {"R1/R2/R3/R7 ", tag}};
        q.push_back(it);
        it = '{3, w, t, anyv, anyv ? 16'(200 + top + 1) : 16'd0, {"R9/R6 ", tag}};
        q.push_back(it);
      end else begin
        it = '{1, m_w, m_t, m_cfg, 16'd0, {"R4/R5 ", tag}};
        q.push_back(it);
      end
    end
    @(negedge clk);
    req_valid = 0; vop_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic take(input int kind);
    item_t it;
    checks++;
    if (q.size() == 0) begin
      fail("R9/R10", "unexpected event kind", 128'(kind), 128'(99));
      return;
    end
    it = q.pop_front();
    if (it.kind != kind) begin
      fail(it.req, "event kind", 128'(kind), 128'(it.kind));
      return;
    end
    case (kind)
      1: if (bank_width !== it.w || bank_type !== it.t || configured !== it.cfg)
           fail(it.req, "state after reject", bank_width ^ bank_type, it.w ^ it.t);
      2: begin
        if (bank_width !== it.w) fail(it.req, "width", bank_width, it.w);
        else if (bank_type !== it.t) fail(it.req, "type", bank_type, it.t);
        else if (configured !== it.cfg) fail(it.req, "configured", 128'(configured), 128'(it.cfg));
        else if (npred_we !== 1'b1 || npred_val !== 4'd0)
          fail(it.req, "predicate count R7", {npred_we, npred_val}, {1'b1, 4'd0});
      end
      3: if (vl_val !== it.mvl || clr_pulse !== 1'b1)
           fail(it.req, "mvl/clear", {clr_pulse, vl_val}, {1'b1, it.mvl});
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    if (monitor_on) begin
      if (vop_trap) take(0);
      if (illegal) take(1);
      if (bank_we) take(2);
      if (vl_load) take(3);
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    checks++;
    if (configured !== 0 || bank_width !== '0 || bank_type !== '0 || vl_val !== 0 ||
        bank_we || illegal || vl_load || clr_pulse || vop_trap)
      fail("R11", "reset state", {configured, vl_val}, 0);
    monitor_on = 1;

    drive(0, 0, '0, 5'd0, 1, "vop while unconfigured");
    drive(1, 1, '0, 5'd1, 0, "R8 imm 1 gives v0 v1 R2");
    drive(1, 0, pack(3, 0, 5, 10, 0, 20, 0, 31, 0), 5'd0, 0, "mixed full word R1");
    drive(1, 0, pack(2, 0, 0, 7, 0, 0, 0, 0, 0), 5'd0, 0, "upper disabled R3");
    drive(1, 0, pack(5, 3, 0, 0, 0, 0, 0, 0, 0), 5'd0, 0, "descending R4");
    drive(1, 0, pack(0, 4, 4, 0, 0, 0, 0, 0, 0), 5'd0, 0, "equal fields R4");
    drive(1, 0, pack(1, 0, 0, 0, 0, 0, 0, 0, 9), 5'd0, 0, "F128 unsupported R5");
    drive(0, 0, '0, 5'd0, 1, "vop while configured R10");
    drive(1, 0, '0, 5'd0, 1, "unconfigure with vop same cycle R6 R10");
    drive(1, 0, pack(0, 0, 0, 0, 0, 0, 6, 12, 0), 5'd0, 1, "configure with vop same cycle R10");
    drive(1, 1, '0, 5'd0, 0, "imm zero unconfigures R8 R6");
    drive(1, 1, '0, 5'd31, 0, "imm 31 all X8 R8");
    drive(1, 0, pack(0, 0, 0, 0, 0, 0, 0, 31, 0), 5'd0, 0, "single X128 R2");
    drive(1, 0, pack(1, 2, 3, 4, 5, 6, 7, 8, 0), 5'd0, 0, "every supported type R1");

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) fail("R9/R10", "missing events", 128'(q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule